// File: doc/BRIEF.md
# Frozen-Word Clock-Domain Crossing

This block carries a multi-bit word that does not count in sequence from one clock domain into a second, unrelated one. The source domain offers the word with a single-cycle load strobe. The block captures the word into a holding register and keeps it frozen there. It then announces the transfer by inverting a request toggle. The destination domain passes that toggle through a chain of flip-flops. It detects the level change and copies the frozen word into its output register. At the same time it raises a one-cycle valid strobe.

The destination then inverts its own acknowledge toggle. That toggle returns to the source domain through a separate flip-flop chain. The source busy output stays high until the returned acknowledge toggle matches the request toggle. While busy is high, the source accepts no new load. This lock guarantees that the holding register never changes while the destination may be sampling it.

Top module: `frozen_word_cdc`

## Requirements
- R1: While a domain's synchronous reset is high, its outputs are held at zero: `src_busy` in the source domain, and `dst_valid` and `dst_word` in the destination domain.
- R2: A load is accepted when `src_load` is 1 and `src_busy` is 0 at a rising `src_clk` edge. After that edge, `src_busy` reads 1.
- R3: A load presented while `src_busy` is 1 is dropped. Its word never appears at `dst_word`, and the frozen holding register keeps its value.
- R4: Every accepted word appears at `dst_word` exactly once, unchanged, and in the order of acceptance.
- R5: Each accepted word produces exactly one `dst_valid` cycle. `dst_valid` is never high on two consecutive `dst_clk` cycles.
- R6: `dst_word` changes only on the `dst_clk` edge at which `dst_valid` goes high. At any other time it holds its value.
- R7: `src_busy` returns to 0 by itself once the destination has taken the word. No further load is needed for this.
- R8: R2 to R7 hold both when the source clock is faster than the destination clock and when it is slower.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| src_clk | input | 1 | Source domain clock |
| src_rst | input | 1 | Source domain synchronous reset, active high |
| src_load | input | 1 | One-cycle request to send `src_word` |
| src_word | input | W | Word to transfer |
| src_busy | output | 1 | High while a transfer awaits acknowledgement |
| dst_clk | input | 1 | Destination domain clock |
| dst_rst | input | 1 | Destination domain synchronous reset, active high |
| dst_word | output | W | Last word received |
| dst_valid | output | 1 | One-cycle strobe marking a new `dst_word` |

## Verification
The interesting collision is in the source domain. A fresh load can land on the very `src_clk` edge where the returning acknowledge clears `src_busy`. The bench provokes this by issuing loads with zero to three cycles of spacing, so that many loads sit exactly on the busy falling edge.

For each load, the bench decides acceptance from the `src_busy` value it samples just before that edge. It queues only accepted words. A word that was wrongly taken or wrongly dropped then shows up as an order or value mismatch at `dst_word`.

// File: rtl/fwc_pkg.sv
package fwc_pkg;

    // Flip-flops between the request toggle and the edge detector (third stage lives in the detector).
    localparam int unsigned REQ_SYNC_STAGES = 2;
    // Flip-flops on the acknowledge return path.
    localparam int unsigned ACK_SYNC_STAGES = 2;

    typedef struct packed {
        logic valid;
        logic ack_tgl;
    } dst_flags_t;

    function automatic logic flip_if(input logic tgl, input logic fire);
        return fire ? ~tgl : tgl;
    endfunction

    function automatic logic level_changed(input logic newer, input logic older);
        return newer ^ older;
    endfunction

endpackage

// File: rtl/fwc_sync_chain.sv
module fwc_sync_chain #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] stage;

    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        if (i == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) stage[0] <= 1'b0;
                else     stage[0] <= d;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) stage[i] <= 1'b0;
                else     stage[i] <= stage[i-1];
            end
        end
    end

    assign q = stage[STAGES-1];
endmodule

// File: rtl/fwc_src_side.sv
module fwc_src_side #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] word_in,
    input  logic         ack_seen,
    output logic         busy,
    output logic         req_tgl,
    output logic [W-1:0] held_word
);
    import fwc_pkg::*;

    logic accept;

    assign accept = load & ~busy;
    assign busy   = req_tgl ^ ack_seen;

    always_ff @(posedge clk) begin
        if (rst) begin
            req_tgl   <= 1'b0;
            held_word <= '0;
        end else begin
            req_tgl <= flip_if(req_tgl, accept);
            if (accept) held_word <= word_in;
        end
    end

    assert_accept_sets_busy_R2: assert property (@(posedge clk) disable iff (rst)
        (load && !busy) |=> busy);

    assert_drop_while_busy_R3: assert property (@(posedge clk) disable iff (rst)
        (load && busy) |=> ($stable(held_word) && $stable(req_tgl)));

    assert_reset_idle_R1: assert property (@(posedge clk)
        rst |=> !busy);
endmodule

// File: rtl/fwc_dst_side.sv
module fwc_dst_side #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         req_synced,
    input  logic [W-1:0] held_word,
    output logic [W-1:0] word_out,
    output logic         valid,
    output logic         ack_tgl
);
    import fwc_pkg::*;

    logic       req_last;
    logic       arrive;
    dst_flags_t flags;

    assign arrive = level_changed(req_synced, req_last);

    always_ff @(posedge clk) begin
        if (rst) begin
            req_last <= 1'b0;
            flags    <= '0;
            word_out <= '0;
        end else begin
            req_last      <= req_synced;
            flags.valid   <= arrive;
            flags.ack_tgl <= flip_if(flags.ack_tgl, arrive);
            if (arrive) word_out <= held_word;
        end
    end

    assign valid   = flags.valid;
    assign ack_tgl = flags.ack_tgl;

    assert_valid_single_R5: assert property (@(posedge clk) disable iff (rst)
        valid |=> !valid);

    assert_word_moves_with_valid_R6: assert property (@(posedge clk) disable iff (rst)
        !$stable(word_out) |-> valid);

    assert_ack_moves_with_valid_R4: assert property (@(posedge clk) disable iff (rst)
        !$stable(ack_tgl) |-> valid);
endmodule

// File: rtl/frozen_word_cdc.sv
module frozen_word_cdc #(
    parameter int unsigned W = 8
) (
    input  logic         src_clk,
    input  logic         src_rst,
    input  logic         src_load,
    input  logic [W-1:0] src_word,
    output logic         src_busy,
    input  logic         dst_clk,
    input  logic         dst_rst,
    output logic [W-1:0] dst_word,
    output logic         dst_valid
);
    import fwc_pkg::*;

    logic         req_tgl;
    logic         req_synced;
    logic         ack_tgl;
    logic         ack_seen;
    logic [W-1:0] held_word;

    fwc_src_side #(.W(W)) u_src (
        .clk(src_clk), .rst(src_rst), .load(src_load), .word_in(src_word),
        .ack_seen(ack_seen), .busy(src_busy), .req_tgl(req_tgl), .held_word(held_word)
    );

    fwc_sync_chain #(.STAGES(REQ_SYNC_STAGES)) u_req_sync (
        .clk(dst_clk), .rst(dst_rst), .d(req_tgl), .q(req_synced)
    );

    fwc_dst_side #(.W(W)) u_dst (
        .clk(dst_clk), .rst(dst_rst), .req_synced(req_synced), .held_word(held_word),
        .word_out(dst_word), .valid(dst_valid), .ack_tgl(ack_tgl)
    );

    fwc_sync_chain #(.STAGES(ACK_SYNC_STAGES)) u_ack_sync (
        .clk(src_clk), .rst(src_rst), .d(ack_tgl), .q(ack_seen)
    );
endmodule

// File: tb/frozen_word_cdc_tb.sv
`timescale 1ns/1ps
module frozen_word_cdc_tb;
    localparam int W = 8;

    real src_half = 2.5;
    real dst_half = 6.5;
    logic src_clk = 0, dst_clk = 0;
    logic src_rst = 1, dst_rst = 1;
    logic src_load = 0;
    logic [W-1:0] src_word = '0;
    logic src_busy, dst_valid;
    logic [W-1:0] dst_word;

    int checks = 0, fails = 0;
    logic [W-1:0] exp_q[$];
    logic mon_on = 0;
    logic prev_valid = 0;
    logic [W-1:0] last_word = '0;

    always #(src_half) src_clk = ~src_clk;
    always #(dst_half) dst_clk = ~dst_clk;

    frozen_word_cdc #(.W(W)) u_dut (
        .src_clk(src_clk), .src_rst(src_rst), .src_load(src_load), .src_word(src_word),
        .src_busy(src_busy), .dst_clk(dst_clk), .dst_rst(dst_rst),
        .dst_word(dst_word), .dst_valid(dst_valid)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [W-1:0] pick_word(input int idx);
        return W'($urandom) ^ W'(idx);
    endfunction

    // Destination monitor: order, value, single strobe, word stability (R4 R5 R6)
    always @(negedge dst_clk) begin
        if (mon_on && !dst_rst) begin
            if (dst_valid) begin
                check(exp_q.size() > 0, "R4 unexpected word", int'(dst_word), -1);
                if (exp_q.size() > 0) begin
                    check(dst_word == exp_q[0], "R4 word value/order", int'(dst_word), int'(exp_q[0]));
                    void'(exp_q.pop_front());
                end
                check(!prev_valid, "R5 valid two cycles", 1, 0);
            end else begin
                check(dst_word == last_word, "R6 word moved without valid", int'(dst_word), int'(last_word));
            end
            prev_valid = dst_valid;
            last_word  = dst_word;
        end
    end

    task automatic do_reset();
        mon_on = 0;
        src_rst = 1; dst_rst = 1;
        repeat (4) @(posedge dst_clk);
        repeat (2) @(posedge src_clk);
        @(negedge src_clk);
        check(src_busy == 0, "R1 busy in reset", int'(src_busy), 0);
        @(negedge dst_clk);
        check(dst_valid == 0, "R1 valid in reset", int'(dst_valid), 0);
        check(dst_word == 0, "R1 word in reset", int'(dst_word), 0);
        prev_valid = 0; last_word = '0;
        exp_q.delete();
        @(negedge src_clk); src_rst = 0;
        @(negedge dst_clk); dst_rst = 0;
        mon_on = 1;
    endtask

    task automatic offer(input logic [W-1:0] w);
        bit taken;
        @(negedge src_clk);
        src_load = 1; src_word = w;
        taken = !src_busy;
        if (taken) exp_q.push_back(w);
        @(negedge src_clk);
        src_load = 0;
        if (taken) check(src_busy == 1, "R2 busy after accept", int'(src_busy), 1);
    endtask

    task automatic drain(input string tag);
        int n = 0;
        while ((src_busy || exp_q.size() != 0) && n < 2000) begin
            @(negedge src_clk); n++;
        end
        check(!src_busy, {"R7 busy released ", tag}, int'(src_busy), 0);
        check(exp_q.size() == 0, {"R4 R8 all delivered ", tag}, exp_q.size(), 0);
    endtask

    task automatic run_phase(input string tag);
        do_reset();
        // Directed: accepted word, then a dropped word while busy (R3)
        offer(8'h3C);
        offer(8'hA5);
        drain(tag);
        check(dst_word == 8'h3C, "R3 dropped word absent", int'(dst_word), 8'h3C);
        for (int i = 0; i < 60; i++) begin
            offer(pick_word(i));
            repeat ($urandom_range(0, 3)) @(negedge src_clk);
        end
        drain(tag);
    endtask

    initial begin
        void'($urandom(32'd1234));
        src_half = 2.5; dst_half = 6.5;   // fast source, slow destination
        run_phase("fast-src");
        src_half = 6.5; dst_half = 2.5;   // slow source, fast destination
        run_phase("slow-src");
        mon_on = 0;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        #400000;
        checks++; fails++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule